// File: doc/BRIEF.md
# Parallel-Chain Logic Self-Test Controller

This block runs a logic self-test over a set of scan chains that all shift at once. A single pseudo-random generator, seen through an XOR spreading network, supplies one new bit per chain on every shift cycle. A multiple-input signature register folds the bit leaving every chain into one running signature. The chains and the logic they surround sit outside the block. The block supplies scan-enable, the per-chain scan-in bits and a one-cycle capture strobe, and it takes back the per-chain scan-out bits.

Software or a test access port sets up the run and then pulses `start`. The setup is the generator seed, the starting signature, the number of patterns, the shift length K (the length of the longest chain) and the signature the run should end with. Each pattern is K shift cycles followed by one capture cycle. After the last capture, K more shift cycles flush the responses into the signature. Chains shorter than K let the first bits of each load fall straight through into the signature. When the run ends, `done_o` rises and the final signature is held. `pass_o` reports whether it matches the expected value.

Top module: `lbist_ctrl`

## Requirements
- R1: A `start` pulse seen while the block is idle or done loads the seed, the starting signature, the pattern count, K and the expected signature, and `busy_o` is high from the next cycle. A `start` seen while `busy_o` is high is ignored, along with every setup input.
- R2: Each pattern is exactly K cycles with `scan_en_o`=1, then one cycle with `capture_o`=1 and `scan_en_o`=0. After the last pattern's capture there are K more cycles with `scan_en_o`=1, then `done_o`=1. A run of N patterns therefore keeps `busy_o` high for N*(K+1)+K cycles.
- R3: A loaded K of 0 is treated as 1. A loaded pattern count of 0 selects the default count given by parameter `PAT_DFLT`.
- R4: The generator is a left-shifting Fibonacci register of `GEN_W` bits. Its new bit 0 is the parity of (state AND `GEN_POLY`), where the default taps at bits 32, 24, 15 and 7 give x^33+x^25+x^16+x^8+1. It advances once per cycle with `scan_en_o`=1 and holds otherwise. A zero seed is replaced by 1.
- R5: While `scan_en_o`=1, `scan_in_o[c]` = g[c mod W] XOR g[(c+A) mod W] XOR g[(c+B) mod W], where g is the current generator state, W is `GEN_W`, A is `PS_OFS_A` (7) and B is `PS_OFS_B` (19). While `scan_en_o`=0, `scan_in_o` is all zero.
- R6: In each cycle with `scan_en_o`=1, the signature becomes {s[MISR_W-2:0], parity(s AND `MISR_POLY`)} XOR the zero-extended `scan_out_i`, with chain c entering bit c. In all other cycles it holds. The signature is visible on `signature_o` at all times.
- R7: `done_o` stays high until the next accepted `start`. `pass_o` is 1 exactly when `done_o` is 1 and `signature_o` equals the loaded expected signature.
- R8: `capture_o` is never high in the same cycle as `scan_en_o`, and it is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle or done |
| seed_i | input | GEN_W | Generator seed |
| sig_init_i | input | MISR_W | Starting signature |
| npat_i | input | CNT_W | Pattern count (0 selects PAT_DFLT) |
| klen_i | input | LEN_W | Shift length K, the longest chain (0 acts as 1) |
| sig_expect_i | input | MISR_W | Expected final signature |
| scan_out_i | input | NCH | Bit leaving each chain |
| scan_en_o | output | 1 | Chains shift when high |
| scan_in_o | output | NCH | Bit entering each chain |
| capture_o | output | 1 | One-cycle capture strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete, signature final |
| pass_o | output | 1 | Final signature matches the expected one |
| signature_o | output | MISR_W | Current signature |

## Verification
The bench builds the block with four chains, a 16-bit signature register with taps at bits 15, 14, 12 and 3, a default pattern count of 6, and the default 33-bit generator. The chains are 7, 3, 5 and 1 bits long, so the longest sets K=7. The three shorter chains then spill early generator bits straight into the signature, and the 1-bit chain passes almost every load bit through. A small default count brings the zero-count and zero-length substitutions within a few dozen cycles. A second, identical run from cleared chains produces a known signature, which makes a matching expected value, and so a pass, reachable.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_CAPT  = 3'd2,
    ST_UNLD  = 3'd3,
    ST_DONE  = 3'd4
  } lbist_state_e;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int              W    = 33,
  parameter logic [W-1:0]    POLY = 33'h1_0100_8080
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state_o
);

  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    logic fb;
    fb = ^(s & POLY);
    return {s[W-2:0], fb};
  endfunction

  logic [W-1:0] seed_fix;
  logic [W-1:0] st_q;

  assign seed_fix = (seed == '0) ? W'(1) : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= W'(1);
    else if (load) st_q <= seed_fix;
    else if (step) st_q <= next_state(st_q);
  end

  assign state_o = st_q;

endmodule

// File: rtl/lbist_phase_shift.sv
module lbist_phase_shift #(
  parameter int GW  = 33,
  parameter int NCH = 16,
  parameter int OA  = 7,
  parameter int OB  = 19
) (
  input  logic [GW-1:0]  gen,
  output logic [NCH-1:0] chan
);

  function automatic logic spread(input logic [GW-1:0] g, input int c);
    return g[c % GW] ^ g[(c + OA) % GW] ^ g[(c + OB) % GW];
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign chan[c] = spread(gen, c);
  end

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int              MW   = 32,
  parameter int              NIN  = 16,
  parameter logic [MW-1:0]   POLY = 32'h8020_0003
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MW-1:0]  init,
  input  logic           step,
  input  logic [NIN-1:0] din,
  output logic [MW-1:0]  sig_o
);

  localparam int PADW = MW - NIN;

  function automatic logic [MW-1:0] fold(input logic [MW-1:0] s, input logic [NIN-1:0] d);
    logic fb;
    fb = ^(s & POLY);
    return {s[MW-2:0], fb} ^ {{PADW{1'b0}}, d};
  endfunction

  logic [MW-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sig_q <= '0;
    else if (load) sig_q <= init;
    else if (step) sig_q <= fold(sig_q, din);
  end

  assign sig_o = sig_q;

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 12,
  parameter int PAT_DFLT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] npat_i,
  input  logic [LEN_W-1:0] klen_i,
  output logic             load_o,
  output logic             scan_en_o,
  output logic             capture_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] k_eff_o
);

  lbist_state_e     state_q;
  logic [LEN_W-1:0] sidx_q, k_q;
  logic [CNT_W-1:0] pidx_q, npat_q;

  logic             run_start, shift_last, pat_last;
  logic [LEN_W-1:0] k_in;
  logic [CNT_W-1:0] n_in;

  assign run_start  = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign shift_last = (sidx_q == k_q - LEN_W'(1));
  assign pat_last   = (pidx_q == npat_q - CNT_W'(1));
  assign k_in       = (klen_i == '0) ? LEN_W'(1) : klen_i;
  assign n_in       = (npat_i == '0) ? CNT_W'(PAT_DFLT) : npat_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sidx_q  <= '0;
      pidx_q  <= '0;
      k_q     <= '0;
      npat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (run_start) begin
            k_q     <= k_in;
            npat_q  <= n_in;
            sidx_q  <= '0;
            pidx_q  <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_last) begin
            sidx_q  <= '0;
            state_q <= ST_CAPT;
          end else begin
            sidx_q <= sidx_q + LEN_W'(1);
          end
        end
        ST_CAPT: begin
          pidx_q  <= pidx_q + CNT_W'(1);
          state_q <= pat_last ? ST_UNLD : ST_SHIFT;
        end
        ST_UNLD: begin
          if (shift_last) begin
            sidx_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            sidx_q <= sidx_q + LEN_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o    = run_start;
  assign scan_en_o = (state_q == ST_SHIFT) || (state_q == ST_UNLD);
  assign capture_o = (state_q == ST_CAPT);
  assign busy_o    = scan_en_o || capture_o;
  assign done_o    = (state_q == ST_DONE);
  assign k_eff_o   = k_q;

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
  parameter int                 GEN_W     = 33,
  parameter logic [GEN_W-1:0]   GEN_POLY  = 33'h1_0100_8080,
  parameter int                 NCH       = 16,
  parameter int                 MISR_W    = 32,
  parameter logic [MISR_W-1:0]  MISR_POLY = 32'h8020_0003,
  parameter int                 PS_OFS_A  = 7,
  parameter int                 PS_OFS_B  = 19,
  parameter int                 CNT_W     = 16,
  parameter int                 LEN_W     = 12,
  parameter int                 PAT_DFLT  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [GEN_W-1:0]  seed_i,
  input  logic [MISR_W-1:0] sig_init_i,
  input  logic [CNT_W-1:0]  npat_i,
  input  logic [LEN_W-1:0]  klen_i,
  input  logic [MISR_W-1:0] sig_expect_i,
  input  logic [NCH-1:0]    scan_out_i,
  output logic              scan_en_o,
  output logic [NCH-1:0]    scan_in_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [MISR_W-1:0] signature_o
);

  logic              load;
  logic [LEN_W-1:0]  k_eff;
  logic [GEN_W-1:0]  gen_q;
  logic [NCH-1:0]    ps_out;
  logic [MISR_W-1:0] expect_q;

  lbist_seq #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .PAT_DFLT(PAT_DFLT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .npat_i(npat_i), .klen_i(klen_i),
    .load_o(load), .scan_en_o(scan_en_o), .capture_o(capture_o),
    .busy_o(busy_o), .done_o(done_o), .k_eff_o(k_eff)
  );

  lbist_prpg #(.W(GEN_W), .POLY(GEN_POLY)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_i),
    .step(scan_en_o), .state_o(gen_q)
  );

  lbist_phase_shift #(
    .GW(GEN_W), .NCH(NCH), .OA(PS_OFS_A), .OB(PS_OFS_B)
  ) u_ps (
    .gen(gen_q), .chan(ps_out)
  );

  lbist_misr #(.MW(MISR_W), .NIN(NCH), .POLY(MISR_POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .load(load), .init(sig_init_i),
    .step(scan_en_o), .din(scan_out_i), .sig_o(signature_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    expect_q <= '0;
    else if (load) expect_q <= sig_expect_i;
  end

  assign scan_in_o = scan_en_o ? ps_out : '0;
  assign pass_o    = done_o && (signature_o == expect_q);

endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
  parameter int LEN_W  = 12,
  parameter int GEN_W  = 33,
  parameter int MISR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              scan_en,
  input logic              capture,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [LEN_W-1:0]  k_eff,
  input logic [GEN_W-1:0]  gen_q,
  input logic [MISR_W-1:0] sig
);

  logic [LEN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (scan_en) run_cnt <= run_cnt + LEN_W'(1);
    else              run_cnt <= '0;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture));

  p_capt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  p_capt_then_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> scan_en);

  p_shift_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (run_cnt == k_eff));

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_busy_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_gen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !start) |=> $stable(gen_q));

  p_gen_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gen_q != '0));

  p_sig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !start) |=> $stable(sig));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_pass_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

endmodule

bind lbist_ctrl lbist_ctrl_chk #(
  .LEN_W(LEN_W), .GEN_W(GEN_W), .MISR_W(MISR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en_o),
  .capture(capture_o), .busy(busy_o), .done(done_o), .pass(pass_o),
  .k_eff(k_eff), .gen_q(gen_q), .sig(signature_o)
);

// File: tb/test_lbist_ctrl.sv
module test_lbist_ctrl;

  localparam int NCH    = 4;
  localparam int GEN_W  = 33;
  localparam int MISR_W = 16;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = 8;
  localparam int DFLT   = 6;
  localparam int CLENS [NCH] = '{7, 3, 5, 1};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [GEN_W-1:0]  seed = '0;
  logic [MISR_W-1:0] sinit = '0;
  logic [CNT_W-1:0]  npat = '0;
  logic [LEN_W-1:0]  klen = '0;
  logic [MISR_W-1:0] sexp = '0;
  logic [NCH-1:0]    scan_out;
  logic              scan_en, capture, busy, done, pass;
  logic [NCH-1:0]    scan_in;
  logic [MISR_W-1:0] signature;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lbist_ctrl #(
    .GEN_W(GEN_W), .NCH(NCH), .MISR_W(MISR_W), .MISR_POLY(16'hD008),
    .CNT_W(CNT_W), .LEN_W(LEN_W), .PAT_DFLT(DFLT)
  ) i_lbist_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_i(seed),
    .sig_init_i(sinit), .npat_i(npat), .klen_i(klen), .sig_expect_i(sexp),
    .scan_out_i(scan_out), .scan_en_o(scan_en), .scan_in_o(scan_in),
    .capture_o(capture), .busy_o(busy), .done_o(done), .pass_o(pass),
    .signature_o(signature)
  );

  // ---------------- scan chains and logic under test (environment) --------
  logic [6:0] chn [NCH];
  logic       chain_clr = 1'b0;

  always_comb begin
    for (int c = 0; c < NCH; c++) scan_out[c] = chn[c][CLENS[c]-1];
  end

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (chain_clr || !rst_n) begin
        chn[c] <= '0;
      end else if (scan_en) begin
        chn[c] <= {chn[c][5:0], scan_in[c]};
      end else if (capture) begin
        for (int i = 0; i < CLENS[c]; i++)
          chn[c][i] <= chn[c][i] ^ chn[c][(i+1) % CLENS[c]] ^ i[0];
      end
    end
  end

  // ---------------- behavioural reference ---------------------------------
  int                m_st = 0;  // 0 idle, 1 shift, 2 capture, 3 unload, 4 done
  int                m_k, m_np, m_si, m_pi;
  logic [GEN_W-1:0]  m_gen = '0;
  logic [MISR_W-1:0] m_sig = '0;
  logic [MISR_W-1:0] m_exp = '0;
  logic              chk_en = 1'b0;

  function automatic logic [GEN_W-1:0] ref_gen(input logic [GEN_W-1:0] s);
    logic b;
    b = s[32] ^ s[24] ^ s[15] ^ s[7];
    return (s << 1) | GEN_W'(b);
  endfunction

  function automatic logic [MISR_W-1:0] ref_sig(input logic [MISR_W-1:0] m,
                                                input logic [NCH-1:0] d);
    logic b;
    logic [MISR_W-1:0] r;
    b = m[15] ^ m[14] ^ m[12] ^ m[3];
    r = (m << 1) | MISR_W'(b);
    for (int c = 0; c < NCH; c++) r[c] = r[c] ^ d[c];
    return r;
  endfunction

  function automatic logic [NCH-1:0] ref_ps(input logic [GEN_W-1:0] g);
    logic [NCH-1:0] o;
    for (int c = 0; c < NCH; c++)
      o[c] = g[c % GEN_W] ^ g[(c + 7) % GEN_W] ^ g[(c + 19) % GEN_W];
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_gen = '0; m_sig = '0; m_exp = '0;
    end else begin
      case (m_st)
        0, 4: if (start) begin
          m_gen = (seed == 0) ? GEN_W'(1) : seed;
          m_sig = sinit;
          m_k   = (klen == 0) ? 1 : int'(klen);
          m_np  = (npat == 0) ? DFLT : int'(npat);
          m_exp = sexp;
          m_si  = 0; m_pi = 0; m_st = 1;
        end
        1, 3: begin
          m_sig = ref_sig(m_sig, scan_out);
          m_gen = ref_gen(m_gen);
          m_si++;
          if (m_si == m_k) begin
            m_si = 0;
            m_st = (m_st == 1) ? 2 : 4;
          end
        end
        2: begin
          m_pi++;
          m_st = (m_pi == m_np) ? 3 : 1;
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      logic sh;
      sh = (m_st == 1) || (m_st == 3);
      check("R2 scan_en", 64'(scan_en), 64'(sh));
      check("R8 capture", 64'(capture), 64'(m_st == 2));
      check("R1 busy", 64'(busy), 64'(m_st >= 1 && m_st <= 3));
      check("R7 done", 64'(done), 64'(m_st == 4));
      check("R5 scan_in", 64'(scan_in), 64'(sh ? ref_ps(m_gen) : '0));
      check("R6 signature", 64'(signature), 64'(m_sig));
      check("R7 pass", 64'(pass), 64'((m_st == 4) && (m_sig == m_exp)));
    end
  end

  // ---------------- stimulus -----------------------------------------------
  task automatic run(input logic [GEN_W-1:0] sd, input logic [MISR_W-1:0] si,
                     input logic [CNT_W-1:0] n, input logic [LEN_W-1:0] k,
                     input logic [MISR_W-1:0] ex, input bit poke,
                     output int cyc, output logic [MISR_W-1:0] sg);
    @(negedge clk);
    seed = sd; sinit = si; npat = n; klen = k; sexp = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      cyc++;
      if (poke && cyc == 4) begin
        seed = 33'h0_0F0F_0F0F; sinit = 16'h1234; npat = 8'd2;
        klen = 8'd3; sexp = 16'hFFFF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    sg = signature;
  endtask

  task automatic clear_chains();
    @(negedge clk);
    chain_clr = 1'b1;
    @(negedge clk);
    chain_clr = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL R2 watchdog: actual hung, expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [MISR_W-1:0] sig_a, sig_b, sig_x;
    repeat (3) @(negedge clk);
    check("R1 reset busy", 64'(busy), 64'(0));
    check("R7 reset done", 64'(done), 64'(0));
    check("R7 reset pass", 64'(pass), 64'(0));
    check("R2 reset scan_en", 64'(scan_en), 64'(0));
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R2: three patterns, K=7 (longest chain), wrong expected value
    clear_chains();
    run(33'h1_2345_6789, 16'hACE1, 8'd3, 8'd7, 16'h0000, 1'b0, cyc, sig_a);
    check("R2 cycle count", 64'(cyc), 64'(3 * 8 + 7));
    check("R7 pass low on mismatch", 64'(pass), 64'(sig_a == 16'h0000));

    // R7: identical run from cleared chains, expected = previous signature
    clear_chains();
    run(33'h1_2345_6789, 16'hACE1, 8'd3, 8'd7, sig_a, 1'b0, cyc, sig_b);
    check("R6 repeat signature", 64'(sig_b), 64'(sig_a));
    check("R7 pass high on match", 64'(pass), 64'(1));
    repeat (5) @(negedge clk);
    check("R7 done held", 64'(done), 64'(1));

    // R3/R4/R1: zero seed, zero count, zero K, with a start poke mid-run
    run('0, 16'h0001, 8'd0, 8'd0, 16'h5555, 1'b1, cyc, sig_x);
    check("R3 default count and K=1", 64'(cyc), 64'(DFLT * 2 + 1));
    check("R1 mid-run start ignored", 64'(cyc), 64'(DFLT * 2 + 1));

    // R2/R6: K shorter than the longest chain
    run(33'h0_DEAD_BEEF, 16'h7777, 8'd4, 8'd2, 16'h0000, 1'b0, cyc, sig_x);
    check("R2 short K cycle count", 64'(cyc), 64'(4 * 3 + 2));

    // R4: one pattern, seed with top bit only
    run(33'h1_0000_0000, 16'hFFFF, 8'd1, 8'd5, 16'h0000, 1'b0, cyc, sig_x);
    check("R2 single pattern count", 64'(cyc), 64'(1 * 6 + 5));

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule